// File: doc/BRIEF.md
# Distributed Arbiter for a Pipelined Shared Bus

Each node on a synchronous, non-pended, pipelined shared bus holds its own copy of this arbiter. The copy watches ten request wires and works out the winner of the next command slot. No central arbiter exists, so every copy must reach the same decision in the same cycle. Eight wires belong to CPU nodes, which take turns under a least-recently-used order. The other two wires belong to the single I/O controller. One of these wires has the highest priority and the other the lowest, and the controller switches between them in a fixed pattern. A partial-block write from the I/O controller is split into a read and a write. The write takes the high wire straight after the read is granted, so no other node can come between the two.

The top module holds the I/O request-wire sequencer once and `COPIES` identical node copies. Each node copy has an LRU stage and a slot tracker, and every copy's grant and tracker view are brought out. The sequencer is a state machine with three states:

- `IO_HIGH_RUN`: a pending I/O request drives the high wire.
- `IO_LOW_RUN`: a pending I/O request drives the low wire.
- `IO_LOCKED`: the high wire is driven whatever the inputs are.

On an I/O grant, both run states advance the pattern position. If `io_partial` is set, the sequencer goes to `IO_LOCKED`. Otherwise it goes to `IO_LOW_RUN` after the sixth high turn, or back to `IO_HIGH_RUN` after the second low turn. When the locked write is granted, `IO_LOCKED` returns to the run state that matches the unchanged position.

The slot tracker records each granted transaction. That transaction has a command cycle, then four data beats at a fixed age, and the stall input freezes the whole pipeline.

Top module: `pbarb_top`

## Requirements
- R1: `grant` has at most one bit set per cycle. Bits 0 to 7 are CPU 0 to 7, bit 8 is the I/O high wire and bit 9 the I/O low wire. Every copy's grant and slot view equals that of copy 0.
- R2: In an arbitration cycle, the I/O high wire beats every CPU request, and any CPU request beats the I/O low wire.
- R3: After reset the CPU order is CPU0 (first) through CPU7 (last). The requesting CPU that comes first in the order wins. The winner moves to last place, and the CPUs behind it each move up one place. The order changes only on a CPU grant.
- R4: With `io_want` held, the I/O request drives the high wire for six grants and then the low wire for two grants, and this repeats. The two wires are never driven together.
- R5: When an I/O grant comes with `io_partial`=1, `io_atomic` rises. The high wire is then driven, ignoring `io_want`/`io_partial`, until the next grant. That next grant goes to the I/O high wire, and it does not advance the pattern.
- R6: In the first unstalled cycle after a grant, `cmd_valid`=1 and `cmd_owner` shows the winner (0 to 7 for a CPU, 8 for I/O).
- R7: Data beats 0 to 3 appear on `data_valid`/`data_owner`/`data_beat` at transaction ages 9 to 12, counted in unstalled cycles from the grant.
- R8: No grant is given until the newest transaction was granted at least four unstalled cycles earlier, so data windows never overlap.
- R9: `in_flight` counts transactions that have not yet sent their last beat. It is at most 3, and no grant is given while it is 3.
- R10: While `stall`=1, no grant, command or data beat is issued, and tracker ages, `in_flight`, the I/O pattern and the LRU order hold.
- R11: After reset, `in_flight`=0, no command or data is shown, `io_atomic`=0 and the pattern is at its first high turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 8 | CPU request wires |
| io_want | input | 1 | I/O controller has a transaction pending |
| io_partial | input | 1 | Pending I/O transaction is a partial-block write |
| stall | input | 1 | Freezes the bus pipeline |
| io_req_hi | output | 1 | I/O high-priority request wire |
| io_req_lo | output | 1 | I/O low-priority request wire |
| io_atomic | output | 1 | Locked write of an atomic pair pending |
| grant | output | 10 | One-hot winner seen by copy 0 |
| copy_grant | output | COPIES*10 | Grant of every node copy |
| copy_slot | output | COPIES*14 | Slot view of every copy {cmd_valid, cmd_owner, data_valid, data_owner, data_beat, in_flight} |
| cmd_valid | output | 1 | Command cycle of a transaction |
| cmd_owner | output | 4 | Owner of the command |
| data_valid | output | 1 | Data beat of a transaction |
| data_owner | output | 4 | Owner of the data beat |
| data_beat | output | 2 | Beat index 0 to 3 |
| in_flight | output | 2 | Outstanding transactions |

## Verification
Some properties are checked on every cycle:

- All copies agree, and the grant is one-hot.
- The high wire takes precedence, and the two I/O wires are exclusive.
- A partial I/O grant arms the lock, and a locked pair allows only the high-wire grant.
- A stall gives quiet outputs and a frozen count.
- A command follows each grant.
- No grant is given at three outstanding transactions.

Other behaviour is visible only through the bench's reference model: the exact LRU order after a run of contended grants, the 6/2 pattern position across mixed traffic, the four-cycle spacing, and beat timing measured in unstalled cycles. The bench drives contended, single-requester, I/O-heavy, partial-write and stall-laden random traffic. It compares every output with the model on every cycle.

// File: rtl/pbarb_pkg.sv
package pbarb_pkg;
    localparam int CPU_COUNT  = 8;
    localparam int LINE_COUNT = CPU_COUNT + 2;
    localparam int HI_LINE    = CPU_COUNT;
    localparam int LO_LINE    = CPU_COUNT + 1;
    localparam int OWNER_W    = $clog2(CPU_COUNT + 1);
    localparam logic [OWNER_W-1:0] IO_OWNER = OWNER_W'(CPU_COUNT);

    typedef enum logic [1:0] {
        IO_HIGH_RUN = 2'd0,
        IO_LOW_RUN  = 2'd1,
        IO_LOCKED   = 2'd2
    } io_state_e;
endpackage

// File: rtl/pbarb_io_seq.sv
module pbarb_io_seq
    import pbarb_pkg::*;
#(
    parameter int HIGH_TURNS = 6,
    parameter int LOW_TURNS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_want,
    input  logic io_partial,
    input  logic io_granted,
    output logic req_hi,
    output logic req_lo,
    output logic locked
);
    localparam int PERIOD = HIGH_TURNS + LOW_TURNS;
    localparam int POS_W  = $clog2(PERIOD);

    io_state_e        state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            IO_HIGH_RUN, IO_LOW_RUN: begin
                if (io_granted) begin
                    pos_d = (pos_q == POS_W'(PERIOD - 1)) ? '0 : pos_q + 1'b1;
                    if (io_partial)
                        state_d = IO_LOCKED;
                    else
                        state_d = (pos_d < POS_W'(HIGH_TURNS)) ? IO_HIGH_RUN : IO_LOW_RUN;
                end
            end
            IO_LOCKED: begin
                if (io_granted)
                    state_d = (pos_q < POS_W'(HIGH_TURNS)) ? IO_HIGH_RUN : IO_LOW_RUN;
            end
            default: state_d = IO_HIGH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IO_HIGH_RUN;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        req_hi = 1'b0;
        req_lo = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            IO_HIGH_RUN: req_hi = io_want;
            IO_LOW_RUN:  req_lo = io_want;
            IO_LOCKED: begin
                req_hi = 1'b1;
                locked = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pbarb_lru.sv
module pbarb_lru #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         upd,
    output logic [N-1:0] win,
    output logic         any
);
    localparam int RW = $clog2(N);

    logic [RW-1:0] rank_q [N];
    logic [RW-1:0] win_rank;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            win[i] = req[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && rank_q[j] < rank_q[i])
                    win[i] = 1'b0;
            end
        end
    end

    assign any = |req;

    always_comb begin
        win_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (win[i])
                win_rank = rank_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                rank_q[i] <= RW'(i);
        end else if (upd) begin
            for (int i = 0; i < N; i++) begin
                if (win[i])
                    rank_q[i] <= RW'(N - 1);
                else if (rank_q[i] > win_rank)
                    rank_q[i] <= rank_q[i] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pbarb_tracker.sv
module pbarb_tracker
    import pbarb_pkg::*;
#(
    parameter int MAX_TXN  = 3,
    parameter int DATA_LAT = 9,
    parameter int BEATS    = 4,
    localparam int LAST_AGE = DATA_LAT + BEATS - 1,
    localparam int AGE_W    = $clog2(LAST_AGE + 1),
    localparam int CNT_W    = $clog2(MAX_TXN + 1),
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               push,
    input  logic [OWNER_W-1:0] push_owner,
    output logic [CNT_W-1:0]   count,
    output logic [AGE_W-1:0]   newest_age,
    output logic               cmd_valid,
    output logic [OWNER_W-1:0] cmd_owner,
    output logic               data_valid,
    output logic [OWNER_W-1:0] data_owner,
    output logic [BEAT_W-1:0]  data_beat
);
    logic [OWNER_W-1:0] own_q [MAX_TXN];
    logic [OWNER_W-1:0] own_d [MAX_TXN];
    logic [AGE_W-1:0]   age_q [MAX_TXN];
    logic [AGE_W-1:0]   age_d [MAX_TXN];
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [OWNER_W-1:0] newest_own;
    logic               retire;

    assign retire = (cnt_q != '0) && (age_q[0] == AGE_W'(LAST_AGE));

    always_comb begin
        own_d = own_q;
        age_d = age_q;
        cnt_d = cnt_q;
        if (!stall) begin
            for (int k = 0; k < MAX_TXN; k++) begin
                if (CNT_W'(k) < cnt_q)
                    age_d[k] = age_q[k] + 1'b1;
            end
            if (retire) begin
                for (int k = 0; k < MAX_TXN - 1; k++) begin
                    own_d[k] = own_d[k+1];
                    age_d[k] = age_d[k+1];
                end
                own_d[MAX_TXN-1] = '0;
                age_d[MAX_TXN-1] = '0;
                cnt_d = cnt_q - 1'b1;
            end
            if (push) begin
                for (int k = 0; k < MAX_TXN; k++) begin
                    if (CNT_W'(k) == cnt_d) begin
                        own_d[k] = push_owner;
                        age_d[k] = AGE_W'(1);
                    end
                end
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_TXN; k++) begin
                own_q[k] <= '0;
                age_q[k] <= '0;
            end
            cnt_q <= '0;
        end else begin
            own_q <= own_d;
            age_q <= age_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        newest_age = '0;
        newest_own = '0;
        for (int k = 0; k < MAX_TXN; k++) begin
            if (CNT_W'(k + 1) == cnt_q) begin
                newest_age = age_q[k];
                newest_own = own_q[k];
            end
        end
    end

    always_comb begin
        count      = cnt_q;
        cmd_valid  = !stall && (cnt_q != '0) && (newest_age == AGE_W'(1));
        cmd_owner  = cmd_valid ? newest_own : '0;
        data_valid = !stall && (cnt_q != '0) &&
                     (age_q[0] >= AGE_W'(DATA_LAT)) && (age_q[0] <= AGE_W'(LAST_AGE));
        data_owner = data_valid ? own_q[0] : '0;
        data_beat  = data_valid ? BEAT_W'(age_q[0] - AGE_W'(DATA_LAT)) : '0;
    end
endmodule

// File: rtl/pbarb_node.sv
module pbarb_node
    import pbarb_pkg::*;
#(
    parameter int MAX_TXN  = 3,
    parameter int DATA_LAT = 9,
    parameter int BEATS    = 4,
    localparam int AGE_W   = $clog2(DATA_LAT + BEATS),
    localparam int CNT_W   = $clog2(MAX_TXN + 1),
    localparam int BEAT_W  = $clog2(BEATS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stall,
    input  logic [CPU_COUNT-1:0]  cpu_req,
    input  logic                  req_hi,
    input  logic                  req_lo,
    output logic [LINE_COUNT-1:0] grant,
    output logic                  cmd_valid,
    output logic [OWNER_W-1:0]    cmd_owner,
    output logic                  data_valid,
    output logic [OWNER_W-1:0]    data_owner,
    output logic [BEAT_W-1:0]     data_beat,
    output logic [CNT_W-1:0]      in_flight
);
    logic [CPU_COUNT-1:0] lru_win;
    logic                 lru_any;
    logic [AGE_W-1:0]     newest_age;
    logic [OWNER_W-1:0]   win_owner;
    logic                 slot_open;

    pbarb_lru #(.N(CPU_COUNT)) lru_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cpu_req),
        .upd   (|grant[CPU_COUNT-1:0]),
        .win   (lru_win),
        .any   (lru_any)
    );

    assign slot_open = !stall && (in_flight < CNT_W'(MAX_TXN)) &&
                       ((in_flight == '0) || (newest_age >= AGE_W'(BEATS)));

    always_comb begin
        grant = '0;
        if (slot_open) begin
            if (req_hi)
                grant[HI_LINE] = 1'b1;
            else if (lru_any)
                grant[CPU_COUNT-1:0] = lru_win;
            else if (req_lo)
                grant[LO_LINE] = 1'b1;
        end
    end

    always_comb begin
        win_owner = IO_OWNER;
        for (int i = 0; i < CPU_COUNT; i++) begin
            if (grant[i])
                win_owner = OWNER_W'(i);
        end
    end

    pbarb_tracker #(
        .MAX_TXN  (MAX_TXN),
        .DATA_LAT (DATA_LAT),
        .BEATS    (BEATS)
    ) trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .push       (|grant),
        .push_owner (win_owner),
        .count      (in_flight),
        .newest_age (newest_age),
        .cmd_valid  (cmd_valid),
        .cmd_owner  (cmd_owner),
        .data_valid (data_valid),
        .data_owner (data_owner),
        .data_beat  (data_beat)
    );
endmodule

// File: rtl/pbarb_top.sv
module pbarb_top
    import pbarb_pkg::*;
#(
    parameter int COPIES     = 3,
    parameter int MAX_TXN    = 3,
    parameter int DATA_LAT   = 9,
    parameter int BEATS      = 4,
    parameter int HIGH_TURNS = 6,
    parameter int LOW_TURNS  = 2,
    localparam int CNT_W     = $clog2(MAX_TXN + 1),
    localparam int BEAT_W    = $clog2(BEATS),
    localparam int SLOT_W    = 2 + 2 * OWNER_W + BEAT_W + CNT_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CPU_COUNT-1:0]         cpu_req,
    input  logic                         io_want,
    input  logic                         io_partial,
    input  logic                         stall,
    output logic                         io_req_hi,
    output logic                         io_req_lo,
    output logic                         io_atomic,
    output logic [LINE_COUNT-1:0]        grant,
    output logic [COPIES*LINE_COUNT-1:0] copy_grant,
    output logic [COPIES*SLOT_W-1:0]     copy_slot,
    output logic                         cmd_valid,
    output logic [OWNER_W-1:0]           cmd_owner,
    output logic                         data_valid,
    output logic [OWNER_W-1:0]           data_owner,
    output logic [BEAT_W-1:0]            data_beat,
    output logic [CNT_W-1:0]             in_flight
);
    logic [LINE_COUNT-1:0] g_a   [COPIES];
    logic                  cv_a  [COPIES];
    logic [OWNER_W-1:0]    co_a  [COPIES];
    logic                  dv_a  [COPIES];
    logic [OWNER_W-1:0]    do_a  [COPIES];
    logic [BEAT_W-1:0]     db_a  [COPIES];
    logic [CNT_W-1:0]      cnt_a [COPIES];

    pbarb_io_seq #(
        .HIGH_TURNS (HIGH_TURNS),
        .LOW_TURNS  (LOW_TURNS)
    ) io_seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_want    (io_want),
        .io_partial (io_partial),
        .io_granted (g_a[0][HI_LINE] | g_a[0][LO_LINE]),
        .req_hi     (io_req_hi),
        .req_lo     (io_req_lo),
        .locked     (io_atomic)
    );

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        pbarb_node #(
            .MAX_TXN  (MAX_TXN),
            .DATA_LAT (DATA_LAT),
            .BEATS    (BEATS)
        ) node_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .stall      (stall),
            .cpu_req    (cpu_req),
            .req_hi     (io_req_hi),
            .req_lo     (io_req_lo),
            .grant      (g_a[c]),
            .cmd_valid  (cv_a[c]),
            .cmd_owner  (co_a[c]),
            .data_valid (dv_a[c]),
            .data_owner (do_a[c]),
            .data_beat  (db_a[c]),
            .in_flight  (cnt_a[c])
        );
        assign copy_grant[c*LINE_COUNT +: LINE_COUNT] = g_a[c];
        assign copy_slot[c*SLOT_W +: SLOT_W] =
            {cv_a[c], co_a[c], dv_a[c], do_a[c], db_a[c], cnt_a[c]};
    end

    assign grant      = g_a[0];
    assign cmd_valid  = cv_a[0];
    assign cmd_owner  = co_a[0];
    assign data_valid = dv_a[0];
    assign data_owner = do_a[0];
    assign data_beat  = db_a[0];
    assign in_flight  = cnt_a[0];
endmodule

// File: rtl/pbarb_chk.sv
module pbarb_chk
    import pbarb_pkg::*;
#(
    parameter int COPIES  = 3,
    parameter int MAX_TXN = 3,
    localparam int CNT_W  = $clog2(MAX_TXN + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         stall,
    input logic                         io_partial,
    input logic                         io_req_hi,
    input logic                         io_req_lo,
    input logic                         io_atomic,
    input logic [LINE_COUNT-1:0]        grant,
    input logic [COPIES*LINE_COUNT-1:0] copy_grant,
    input logic                         cmd_valid,
    input logic                         data_valid,
    input logic [CNT_W-1:0]             in_flight
);
    // R1
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_grant == {COPIES{grant}});
    // R1
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2
    high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_hi && (|grant)) |-> grant[HI_LINE]);
    // R4
    wires_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_req_hi && io_req_lo));
    // R5
    lock_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant[HI_LINE] || grant[LO_LINE]) && io_partial && !io_atomic) |=> io_atomic);
    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_atomic && (|grant)) |-> grant[HI_LINE]);
    // R6
    cmd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (cmd_valid || stall));
    // R9
    cap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight == CNT_W'(MAX_TXN)) |-> !(|grant));
    // R9
    cap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight <= CNT_W'(MAX_TXN));
    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!(|grant) && !cmd_valid && !data_valid));
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(in_flight));
endmodule

bind pbarb_top pbarb_chk #(
    .COPIES  (COPIES),
    .MAX_TXN (MAX_TXN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall      (stall),
    .io_partial (io_partial),
    .io_req_hi  (io_req_hi),
    .io_req_lo  (io_req_lo),
    .io_atomic  (io_atomic),
    .grant      (grant),
    .copy_grant (copy_grant),
    .cmd_valid  (cmd_valid),
    .data_valid (data_valid),
    .in_flight  (in_flight)
);

// File: tb/pbarb_top_tb_top.sv
module pbarb_top_tb_top;
    import pbarb_pkg::*;

    localparam int COPIES = 3;
    localparam int MAXT   = 3;
    localparam int DLAT   = 9;
    localparam int BEATS  = 4;
    localparam int HT     = 6;
    localparam int LT     = 2;
    localparam int SLOT_W = 2 + 2 * OWNER_W + 2 + 2;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [7:0]                   cpu_req = '0;
    logic                         io_want = 1'b0;
    logic                         io_partial = 1'b0;
    logic                         stall = 1'b0;
    logic                         io_req_hi, io_req_lo, io_atomic;
    logic [9:0]                   grant;
    logic [COPIES*10-1:0]         copy_grant;
    logic [COPIES*SLOT_W-1:0]     copy_slot;
    logic                         cmd_valid, data_valid;
    logic [3:0]                   cmd_owner, data_owner;
    logic [1:0]                   data_beat, in_flight;

    pbarb_top #(.COPIES(COPIES), .MAX_TXN(MAXT), .DATA_LAT(DLAT), .BEATS(BEATS),
                .HIGH_TURNS(HT), .LOW_TURNS(LT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .io_want(io_want),
        .io_partial(io_partial), .stall(stall), .io_req_hi(io_req_hi),
        .io_req_lo(io_req_lo), .io_atomic(io_atomic), .grant(grant),
        .copy_grant(copy_grant), .copy_slot(copy_slot), .cmd_valid(cmd_valid),
        .cmd_owner(cmd_owner), .data_valid(data_valid), .data_owner(data_owner),
        .data_beat(data_beat), .in_flight(in_flight)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int order_q[$];
    int io_pos;
    bit io_lock;
    int t_own[$];
    int t_age[$];

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        order_q.delete();
        for (int i = 0; i < 8; i++) order_q.push_back(i);
        io_pos  = 0;
        io_lock = 0;
        t_own.delete();
        t_age.delete();
    endfunction

    task automatic step();
        bit ehi, elo, allow, ecv, edv;
        int n, win, eco, edo, edb;
        ehi = io_lock || (io_want && io_pos < HT);
        elo = !io_lock && io_want && io_pos >= HT;
        n = t_own.size();
        allow = !stall && n < MAXT && (n == 0 || t_age[n-1] >= BEATS);
        win = -1;
        if (allow) begin
            if (ehi) win = 8;
            else begin
                foreach (order_q[k])
                    if (win < 0 && cpu_req[order_q[k]]) win = order_q[k];
                if (win < 0 && elo) win = 9;
            end
        end
        ecv = !stall && n > 0 && t_age[n-1] == 1;
        eco = ecv ? t_own[n-1] : 0;
        edv = !stall && n > 0 && t_age[0] >= DLAT && t_age[0] <= DLAT + BEATS - 1;
        edo = edv ? t_own[0] : 0;
        edb = edv ? t_age[0] - DLAT : 0;

        check("R2 R3 R8 R9 R10 grant", int'(grant), (win >= 0) ? (1 << win) : 0);
        check("R4 R5 io_req_hi", int'(io_req_hi), int'(ehi));
        check("R4 io_req_lo", int'(io_req_lo), int'(elo));
        check("R5 io_atomic", int'(io_atomic), int'(io_lock));
        check("R6 cmd_valid", int'(cmd_valid), int'(ecv));
        check("R6 cmd_owner", int'(cmd_owner), eco);
        check("R7 data_valid", int'(data_valid), int'(edv));
        check("R7 data_owner", int'(data_owner), edo);
        check("R7 data_beat", int'(data_beat), edb);
        check("R9 in_flight", int'(in_flight), n);
        for (int c = 1; c < COPIES; c++) begin
            check("R1 copy grant", int'(copy_grant[c*10 +: 10]), int'(copy_grant[9:0]));
            check("R1 copy slot", int'(copy_slot[c*SLOT_W +: SLOT_W]),
                  int'(copy_slot[SLOT_W-1:0]));
        end

        if (!stall) begin
            foreach (t_age[k]) t_age[k]++;
            if (t_age.size() > 0 && t_age[0] > DLAT + BEATS - 1) begin
                void'(t_age.pop_front());
                void'(t_own.pop_front());
            end
            if (win >= 0) begin
                t_own.push_back(win < 8 ? win : 8);
                t_age.push_back(1);
                if (win < 8) begin
                    foreach (order_q[k])
                        if (order_q[k] == win) begin order_q.delete(k); break; end
                    order_q.push_back(win);
                end else if (io_lock) begin
                    io_lock = 0;
                end else begin
                    io_pos = (io_pos + 1) % (HT + LT);
                    if (io_partial) io_lock = 1;
                end
            end
        end
    endtask

    task automatic cycle(logic [7:0] cr, logic iw, logic ip, logic st);
        @(negedge clk);
        cpu_req = cr; io_want = iw; io_partial = ip; stall = st;
        #1;
        step();
    endtask

    initial begin
        model_reset();
        repeat (3) begin
            @(negedge clk);
            #1;
            // R11 reset state
            check("R11 in_flight", int'(in_flight), 0);
            check("R11 cmd_valid", int'(cmd_valid), 0);
            check("R11 data_valid", int'(data_valid), 0);
            check("R11 io_atomic", int'(io_atomic), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R11: first I/O request uses the high wire
        io_want = 1'b1;
        #1;
        check("R11 first turn high", int'(io_req_hi), 1);
        io_want = 1'b0;
        #1;
        step();

        // R3 single requesters walking
        for (int k = 0; k < 40; k++) cycle(8'(1 << ((k / 5) % 8)), 0, 0, 0);
        // R3 R9 full CPU contention
        for (int k = 0; k < 200; k++) cycle(8'hFF, 0, 0, 0);
        // R3 partial contention
        for (int k = 0; k < 120; k++) cycle(8'h5A, 0, 0, 0);
        // R2 R4 I/O pattern against CPUs
        for (int k = 0; k < 250; k++) cycle(8'hA5, 1, 0, 0);
        // R4 I/O alone
        for (int k = 0; k < 120; k++) cycle(8'h00, 1, 0, 0);
        // R5 partial writes under contention
        for (int k = 0; k < 150; k++) cycle(8'hFF, 1, (k % 3) == 0, 0);
        // R10 long stall mid-traffic
        for (int k = 0; k < 30; k++) cycle(8'hFF, 1, 0, (k >= 6 && k < 26));
        // random mix
        for (int k = 0; k < 3000; k++)
            cycle(8'($urandom_range(0, 255) & $urandom_range(0, 255)),
                  ($urandom_range(0, 2) != 0), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 7) == 0));
        // drain
        for (int k = 0; k < 30; k++) cycle(8'h00, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule